// File: doc/BRIEF.md
# Duty-Limited Tri-Colour LED Dimmer

This block drives the three colour inputs of a single red/green/blue LED with pulse-width modulated waveforms. Each colour has its own 8-bit brightness level. A high output lights that colour. Colours mix by overlap: red and blue at equal level with green dark gives purple. The period counter is shared, so every channel's on-time starts on the same clock. The on-time is limited by construction to less than half of the period. A channel can therefore never sit at a constant high level, even at its largest setting.

New levels for all three colours arrive together as one transfer on a valid/ready port. `lvl_ready` is high whenever the block is out of reset, so the port never applies back-pressure. A transfer happens on any rising clock edge where `lvl_valid` and `lvl_ready` are both high. The accepted triple is held as pending. The running levels take the pending value only when the period counter rolls over, so a period already in progress always completes with the levels it started with. If several transfers land in one period, the last one is used. While `rst` is high, `lvl_ready` is low and nothing is accepted. To drive two LEDs, instantiate the block twice.

Top module: `rgb_pwm_driver`

## Requirements
- R1: A synchronous, active-high `rst` clears the phase counter, the pending levels and the running levels, and drives all three outputs low from the first clock edge at which it is seen. After release, the first full period is dark on every channel.
- R2: The PWM period is exactly 512 clocks, counted by one 9-bit phase counter that all channels share. Phase 0 is the first clock after reset is released. Every nonzero channel goes high at phase 0 of each period.
- R3: With a running level v (0 to 255), a channel is high for phases 0 to v-1 and low for phases v to 511. It can only rise at phase 0.
- R4: No output is ever high at phase 256 or later. The largest level, 255, gives 255 high clocks out of 512, so no output stays high across a whole period.
- R5: A running level of 0 keeps the output low for the entire period.
- R6: The three channels are independent. Each output depends only on its own level field: red on `lvl_red`, green on `lvl_green`, blue on `lvl_blue`.
- R7: `lvl_ready` equals the inverse of `rst`. An accepted transfer does not change the period in progress; it becomes the running level at phase 0 of the next period.
- R8: A transfer accepted on the edge that ends phase 511 misses that rollover. The levels running before it are used for one more period, and the new levels run from the period after that.
- R9: When more than one transfer is accepted within one period, only the last one reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_valid | input | 1 | A new level triple is offered |
| lvl_ready | output | 1 | Triple can be accepted (low only in reset) |
| lvl_red | input | 8 | Red brightness level |
| lvl_green | input | 8 | Green brightness level |
| lvl_blue | input | 8 | Blue brightness level |
| led_red | output | 1 | Red drive, high lights the colour |
| led_green | output | 1 | Green drive, high lights the colour |
| led_blue | output | 1 | Blue drive, high lights the colour |

## Verification
The bench samples every phase of each period and compares it with the on-window that the level implies, so it also catches on-time shifted by a clock. Full scale (255) checks the half-period ceiling: a comparator one bit too wide would light phases 256 and up, or hold the output steadily high. A transfer on the final phase of a period, and a period with two transfers, catch a design that loads levels straight away (mid-period glitches), one that loads on the wrong edge, or one that keeps the first write. A reset in the middle of a lit period catches running or pending levels that survive reset and light the following period.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;
  localparam int unsigned LVL_W_DEF = 8;
  localparam int unsigned N_CH      = 3;
  typedef enum int unsigned {CH_RED = 0, CH_GREEN = 1, CH_BLUE = 2} chan_e;
endpackage

// File: rtl/rgb_pwm_phase.sv
module rgb_pwm_phase #(
  parameter int unsigned LVL_W = rgb_pwm_pkg::LVL_W_DEF,
  localparam int unsigned CNT_W = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrap
);
  // Period is a power of two, so the increment rolls over by itself.
  assign wrap     = (cnt_q == {CNT_W{1'b1}});
  assign cnt_next = rst ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    cnt_q <= cnt_next;
  end

  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/rgb_pwm_chan.sv
module rgb_pwm_chan #(
  parameter int unsigned LVL_W = rgb_pwm_pkg::LVL_W_DEF,
  localparam int unsigned CNT_W = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             load,
  input  logic [LVL_W-1:0] load_lvl,
  output logic             pwm
);
  logic [LVL_W-1:0] pend_q, act_q, act_next;
  logic             pwm_q;

  // The running level is one bit narrower than the phase, so the
  // comparison can never be true in the upper half of the period.
  assign act_next = rst ? '0 : (wrap ? pend_q : act_q);

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= '0;
    else if (load) pend_q <= load_lvl;
    act_q <= act_next;
    pwm_q <= ({1'b0, act_next} > cnt_next);
  end

  assign pwm = pwm_q;

  a_r5_zero_dark: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |-> !pwm_q);
  a_r7_level_held: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (act_q == $past(act_q)));
  a_r3_falls_at_level: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_q) && cnt_q != '0) |-> (cnt_q == {1'b0, act_q}));
endmodule

// File: rtl/rgb_pwm_driver.sv
module rgb_pwm_driver #(
  parameter int unsigned LVL_W = rgb_pwm_pkg::LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_valid,
  output logic             lvl_ready,
  input  logic [LVL_W-1:0] lvl_red,
  input  logic [LVL_W-1:0] lvl_green,
  input  logic [LVL_W-1:0] lvl_blue,
  output logic             led_red,
  output logic             led_green,
  output logic             led_blue
);
  import rgb_pwm_pkg::*;
  localparam int unsigned CNT_W = LVL_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             wrap;
  logic             accept;
  logic [LVL_W-1:0] lvl_in [N_CH];
  logic [N_CH-1:0]  pwm_out;

  assign lvl_ready = ~rst;
  assign accept    = lvl_valid & lvl_ready;

  assign lvl_in[CH_RED]   = lvl_red;
  assign lvl_in[CH_GREEN] = lvl_green;
  assign lvl_in[CH_BLUE]  = lvl_blue;

  rgb_pwm_phase #(.LVL_W(LVL_W)) u_phase (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_next(cnt_next), .wrap(wrap)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    rgb_pwm_chan #(.LVL_W(LVL_W)) u_chan (
      .clk(clk), .rst(rst), .wrap(wrap), .cnt_q(cnt_q),
      .cnt_next(cnt_next), .load(accept), .load_lvl(lvl_in[ch]),
      .pwm(pwm_out[ch])
    );
  end

  assign led_red   = pwm_out[CH_RED];
  assign led_green = pwm_out[CH_GREEN];
  assign led_blue  = pwm_out[CH_BLUE];

  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> (pwm_out == '0 && cnt_q == '0));
  a_r4_upper_half_dark: assert property (@(posedge clk) disable iff (rst)
    cnt_q[CNT_W-1] |-> (pwm_out == '0));
  a_r2_common_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwm_out[CH_RED]) || $rose(pwm_out[CH_GREEN]) ||
     $rose(pwm_out[CH_BLUE])) |-> (cnt_q == '0));
  a_r7_ready_follows_reset: assert property (@(posedge clk)
    lvl_ready == !rst);
endmodule

// File: tb/rgb_pwm_driver_bench.sv
module rgb_pwm_driver_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PER = 512;
  localparam int  NV  = 7;
  localparam logic [23:0] VEC [NV] = '{
    24'hFF00FF, 24'h0180FE, 24'h000000, 24'hC8C8C8,
    24'hFFFFFF, 24'h114003, 24'h800001
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lvl_valid = 1'b0;
  logic [7:0] lvl_red = '0, lvl_green = '0, lvl_blue = '0;
  logic lvl_ready, led_red, led_green, led_blue;
  int n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_pwm_driver u_rgb_pwm_driver (
    .clk(clk), .rst(rst), .lvl_valid(lvl_valid), .lvl_ready(lvl_ready),
    .lvl_red(lvl_red), .lvl_green(lvl_green), .lvl_blue(lvl_blue),
    .led_red(led_red), .led_green(led_green), .led_blue(led_blue)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One period sampled at falling edges, phase k at the k-th sample.
  // Optional transfers at phases k1 and k2; stop_k < PER ends early.
  task automatic run_period(input logic [23:0] exp, input string req,
                            input int k1, input logic [23:0] w1,
                            input int k2, input logic [23:0] w2,
                            input int stop_k);
    int bad_r = 0, bad_g = 0, bad_b = 0, hi_r = 0, hi_g = 0, hi_b = 0;
    for (int k = 0; k < stop_k; k++) begin
      hi_r += int'(led_red); hi_g += int'(led_green); hi_b += int'(led_blue);
      if (led_red   !== (k < int'(exp[23:16]))) bad_r++;
      if (led_green !== (k < int'(exp[15:8])))  bad_g++;
      if (led_blue  !== (k < int'(exp[7:0])))   bad_b++;
      lvl_valid = 1'b0;
      if (k == k1) begin
        lvl_valid = 1'b1; {lvl_red, lvl_green, lvl_blue} = w1;
      end
      if (k == k2) begin
        lvl_valid = 1'b1; {lvl_red, lvl_green, lvl_blue} = w2;
      end
      @(negedge clk);
    end
    lvl_valid = 1'b0;
    if (stop_k == PER) begin
      check(bad_r == 0, {req, " red"},   hi_r, int'(exp[23:16]));
      check(bad_g == 0, {req, " green"}, hi_g, int'(exp[15:8]));
      check(bad_b == 0, {req, " blue"},  hi_b, int'(exp[7:0]));
    end else begin
      check(bad_r + bad_g + bad_b == 0, {req, " partial"}, bad_r + bad_g + bad_b, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    // R1: reset state; R7: ready low in reset
    check({led_red, led_green, led_blue} == 3'b000, "R1 outputs low in reset",
          int'({led_red, led_green, led_blue}), 0);
    check(lvl_ready == 1'b0, "R7 ready low in reset", int'(lvl_ready), 0);
    rst = 1'b0;
    #1;
    check(lvl_ready == 1'b1, "R7 ready high after reset", int'(lvl_ready), 1);

    // Table: period i shows the levels written during period i-1 (R2 R3 R4 R5 R6 R7)
    run_period(24'h0, "R1 first period dark", 37, VEC[0], -1, 24'h0, PER);
    for (int i = 1; i <= NV; i++) begin
      run_period(VEC[i-1], "R3/R6 table level", (i < NV) ? (37*i + 5) % PER : -1,
                 (i < NV) ? VEC[i] : 24'h0, -1, 24'h0, PER);
    end

    // R9: two transfers in one period, last one wins
    run_period(VEC[NV-1], "R9 current kept", 50, 24'h0A141E, 400, 24'h5A3C1E, PER);
    run_period(24'h5A3C1E, "R9 last write", -1, 24'h0, -1, 24'h0, PER);

    // R8: transfer on the final phase takes effect one period later
    run_period(24'h5A3C1E, "R8 write at 511", 511, 24'h05FA64, -1, 24'h0, PER);
    run_period(24'h5A3C1E, "R8 old level repeats", -1, 24'h0, -1, 24'h0, PER);
    run_period(24'h05FA64, "R8 new level", 20, 24'hFFFFFF, -1, 24'h0, PER);

    // R4: full scale on all channels, then R1: reset mid-period
    run_period(24'hFFFFFF, "R4 full scale half period", -1, 24'h0, -1, 24'h0, PER);
    run_period(24'hFFFFFF, "R1 before mid reset", -1, 24'h0, -1, 24'h0, 100);
    rst = 1'b1;
    @(negedge clk);
    check({led_red, led_green, led_blue} == 3'b000, "R1 reset forces low",
          int'({led_red, led_green, led_blue}), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_period(24'h0, "R1 dark after mid reset", -1, 24'h0, -1, 24'h0, PER);
    run_period(24'h0, "R5 pending cleared by reset", -1, 24'h0, -1, 24'h0, PER);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule